// File: doc/BRIEF.md
# SD Bus Cycle-Timing Monitor

This block watches an SD/MMC command channel through event markers supplied by an upstream framer and measures, in bus-clock cycles, the spacing between protocol events: command end to response start, response end to the next command, command to command, write response to write data, stop command to data stop, and read command to read data. Each spacing is compared against its allowed window. When a window is broken, a one-cycle violation pulse is raised on the bit for that rule, together with a numeric code naming the rule. The same bit is latched in a sticky error register that software-side logic clears by writing ones.

The monitor runs entirely on the bus clock, and each marker is a single-cycle pulse. The kind of each command (ordinary, identification, read, write, stop) is presented with its end marker. The read access window is programmable: its upper bound is an access-time term plus a second term scaled by 100 cycles. The raw command line level is also observed, so that a response that never starts can be reported on its own timeout bit.

Top module: `sd_gap_monitor`

## Requirements
- R1: For a non-identification command, a response start 0 or 1 cycles after the command end pulses rule bit 0; more than 64 cycles pulses rule bit 1; 2 to 64 cycles pulses neither. A gap is the number of rising edges from the reference marker to the target marker.
- R2: For an identification command (kind 1), a response start at any gap other than exactly 5 pulses rule bit 2.
- R3: A command start fewer than 8 cycles after a response end pulses rule bit 3.
- R4: A command start fewer than 8 cycles after a command end with no response start in between pulses rule bit 4.
- R5: For a write command (kind 3), write data starting fewer than 2 cycles after its response end pulses rule bit 5.
- R6: After a stop command (kind 4), a data-stop marker at any gap other than 2 pulses rule bit 6, and so does an absent marker, at gap 3.
- R7: After a read command (kind 2), read data at a gap below 2 or above taac + 100*nsac pulses rule bit 7, and so does absent data, at gap limit+1.
- R8: When 65 cycles pass after a command end with no response start and the command line held high the whole time, rule bit 8 pulses; a low level on the command line during the wait suppresses it.
- R9: Each violation sets its bit in the sticky error register in the same cycle as its pulse. The bit holds until a one is written to the matching clear bit. A set in the same cycle as a clear wins.
- R10: The valid output is high exactly when any rule bit pulses, and the code output then gives the lowest-numbered rule bit that is pulsing.
- R11: After reset, all pulses, the valid output, the code and the sticky register are zero.
- R12: Gap counters saturate at 255, so a response arriving after a very long gap (e.g. 300 cycles) is still reported on rule bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_line | input | 1 | Command line level |
| cmd_start | input | 1 | Pulse: command start bit seen |
| cmd_end | input | 1 | Pulse: command end bit seen |
| cmd_kind | input | 3 | Command kind, valid with cmd_end (0 normal, 1 ident, 2 read, 3 write, 4 stop) |
| rsp_start | input | 1 | Pulse: response start bit seen |
| rsp_end | input | 1 | Pulse: response end bit seen |
| wdat_start | input | 1 | Pulse: write data start |
| rdat_start | input | 1 | Pulse: read data start |
| dat_stop | input | 1 | Pulse: data transfer stopped |
| acc_taac | input | 8 | Read access term in cycles |
| acc_nsac | input | 8 | Read access term in units of 100 cycles |
| err_clr | input | 9 | Write-one-to-clear for the sticky bits |
| viol | output | 9 | Registered per-rule violation pulses |
| viol_valid | output | 1 | Any rule violated this cycle |
| viol_code | output | 4 | Lowest violated rule number |
| err_sticky | output | 9 | Sticky per-rule error bits |

## Verification
Each window is tried at gaps on both sides of each bound: just inside it, one cycle outside it, and, for exact windows, one cycle on either side. This tells an off-by-one compare or a wrong limit apart from a correct one. The missing-marker cases (no response, no data-stop, no read data) are kept apart from late markers, and the timeout is run both with a quiet command line and with a start bit during the wait. A 300-cycle gap shows saturation rather than wrap-around, and a same-cycle double violation exercises the code priority and the clear-versus-set ordering.

// File: rtl/sd_gap_pkg.sv
package sd_gap_pkg;
  localparam int NRULE  = 9;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    K_NORM  = 3'd0,
    K_IDENT = 3'd1,
    K_READ  = 3'd2,
    K_WRITE = 3'd3,
    K_STOP  = 3'd4
  } cmd_kind_e;

  // rule bit positions; lower index wins in the code output
  localparam int V_RSP_EARLY = 0;
  localparam int V_RSP_LATE  = 1;
  localparam int V_ID_GAP    = 2;
  localparam int V_RSP_CMD   = 3;
  localparam int V_CMD_CMD   = 4;
  localparam int V_WR_GAP    = 5;
  localparam int V_STOP_GAP  = 6;
  localparam int V_ACC_GAP   = 7;
  localparam int V_NO_RSP    = 8;
endpackage

// File: rtl/sd_gap_timer.sv
module sd_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CMAX;
    else if (restart)    cnt <= ONE;
    else if (cnt != CMAX) cnt <= cnt + ONE;
  end

  // R12: a saturated counter stays saturated until restarted
  a_r12_hold_sat: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && !restart) |=> cnt == CMAX);

  a_r12_restart_one: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == ONE);
endmodule

// File: rtl/sd_gap_rules.sv
module sd_gap_rules
  import sd_gap_pkg::*;
#(
  parameter int GAP_W      = 8,
  parameter int ACC_W      = 16,
  parameter int NCR_MIN    = 2,
  parameter int NCR_MAX    = 64,
  parameter int NID_GAP    = 5,
  parameter int NRC_MIN    = 8,
  parameter int NCC_MIN    = 8,
  parameter int NWR_MIN    = 2,
  parameter int NST_GAP    = 2,
  parameter int NAC_MIN    = 2,
  parameter int TO_LIM     = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_line,
  input  logic             cmd_start,
  input  logic             cmd_end,
  input  logic [2:0]       cmd_kind,
  input  logic             rsp_start,
  input  logic             rsp_end,
  input  logic             wdat_start,
  input  logic             rdat_start,
  input  logic             dat_stop,
  input  logic [ACC_W-1:0] acc_lim,
  input  logic [GAP_W-1:0] t_cmd,
  input  logic [GAP_W-1:0] t_rsp,
  input  logic [ACC_W-1:0] t_acc,
  output logic [NRULE-1:0] viol_d
);
  localparam logic [GAP_W-1:0] L_NCR_MIN = GAP_W'(NCR_MIN);
  localparam logic [GAP_W-1:0] L_NCR_MAX = GAP_W'(NCR_MAX);
  localparam logic [GAP_W-1:0] L_NID     = GAP_W'(NID_GAP);
  localparam logic [GAP_W-1:0] L_NRC     = GAP_W'(NRC_MIN);
  localparam logic [GAP_W-1:0] L_NCC     = GAP_W'(NCC_MIN);
  localparam logic [GAP_W-1:0] L_NWR     = GAP_W'(NWR_MIN);
  localparam logic [GAP_W-1:0] L_NST     = GAP_W'(NST_GAP);
  localparam logic [GAP_W-1:0] L_NST_MISS = GAP_W'(NST_GAP + 1);
  localparam logic [GAP_W-1:0] L_TO      = GAP_W'(TO_LIM + 1);
  localparam logic [ACC_W-1:0] L_NAC     = ACC_W'(NAC_MIN);

  logic wait_rsp, id_q, bit_seen, to_done;
  logic rsp_last, wr_q, wr_armed, stop_armed, rd_armed;
  logic rsp_hit, stop_hit, acc_hit, to_hit;

  assign rsp_hit  = rsp_start && wait_rsp;
  assign to_hit   = wait_rsp && !bit_seen && !to_done && cmd_line &&
                    !rsp_start && (t_cmd == L_TO);
  assign stop_hit = stop_armed &&
                    (dat_stop ? (t_cmd != L_NST) : (t_cmd == L_NST_MISS));
  assign acc_hit  = rd_armed &&
                    (rdat_start ? (t_acc < L_NAC || t_acc > acc_lim)
                                : (t_acc == acc_lim + ACC_W'(1)));

  always_comb begin
    viol_d              = '0;
    viol_d[V_RSP_EARLY] = rsp_hit && !id_q && (t_cmd < L_NCR_MIN);
    viol_d[V_RSP_LATE]  = rsp_hit && !id_q && (t_cmd > L_NCR_MAX);
    viol_d[V_ID_GAP]    = rsp_hit && id_q && (t_cmd != L_NID);
    viol_d[V_RSP_CMD]   = cmd_start && rsp_last && (t_rsp < L_NRC);
    viol_d[V_CMD_CMD]   = cmd_start && wait_rsp && (t_cmd < L_NCC);
    viol_d[V_WR_GAP]    = wdat_start && wr_armed && (t_rsp < L_NWR);
    viol_d[V_STOP_GAP]  = stop_hit;
    viol_d[V_ACC_GAP]   = acc_hit;
    viol_d[V_NO_RSP]    = to_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_rsp   <= 1'b0;
      id_q       <= 1'b0;
      bit_seen   <= 1'b0;
      to_done    <= 1'b0;
      rsp_last   <= 1'b0;
      wr_q       <= 1'b0;
      wr_armed   <= 1'b0;
      stop_armed <= 1'b0;
      rd_armed   <= 1'b0;
    end else begin
      if (to_hit)                 to_done  <= 1'b1;
      if (wait_rsp && !cmd_line)  bit_seen <= 1'b1;
      if (rsp_hit)                wait_rsp <= 1'b0;
      if (rsp_end) begin
        rsp_last <= 1'b1;
        wr_armed <= wr_q;
      end
      if (wdat_start)             wr_armed   <= 1'b0;
      if (stop_hit || dat_stop)   stop_armed <= 1'b0;
      if (acc_hit || rdat_start)  rd_armed   <= 1'b0;
      if (cmd_start) begin
        wait_rsp <= 1'b0;
        rsp_last <= 1'b0;
      end
      if (cmd_end) begin
        wait_rsp   <= 1'b1;
        bit_seen   <= 1'b0;
        to_done    <= 1'b0;
        id_q       <= (cmd_kind == K_IDENT);
        wr_q       <= (cmd_kind == K_WRITE);
        stop_armed <= (cmd_kind == K_STOP);
        rd_armed   <= (cmd_kind == K_READ);
      end
    end
  end

  // R8: a start bit on the line blocks the timeout in the following cycle
  a_r8_start_bit_blocks: assert property (@(posedge clk) disable iff (rst)
    (wait_rsp && !cmd_line) |=> !viol_d[V_NO_RSP]);

  // R6: a stop window is judged once only
  a_r6_stop_once: assert property (@(posedge clk) disable iff (rst)
    (viol_d[V_STOP_GAP] && !cmd_end) |=> !viol_d[V_STOP_GAP]);

  // R7: a read window is judged once only
  a_r7_acc_once: assert property (@(posedge clk) disable iff (rst)
    (viol_d[V_ACC_GAP] && !cmd_end) |=> !viol_d[V_ACC_GAP]);
endmodule

// File: rtl/sd_gap_log.sv
module sd_gap_log
  import sd_gap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NRULE-1:0]  viol_d,
  input  logic [NRULE-1:0]  err_clr,
  output logic [NRULE-1:0]  viol,
  output logic              viol_valid,
  output logic [CODE_W-1:0] viol_code,
  output logic [NRULE-1:0]  err_sticky
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (viol_d[i]) code_d = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol       <= '0;
      viol_valid <= 1'b0;
      viol_code  <= '0;
      err_sticky <= '0;
    end else begin
      viol       <= viol_d;
      viol_valid <= |viol_d;
      viol_code  <= code_d;
      err_sticky <= (err_sticky & ~err_clr) | viol_d;
    end
  end

  // R9: a set bit that is not cleared stays set
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_sticky & $past(err_sticky & ~err_clr)) ==
              $past(err_sticky & ~err_clr)));

  // R9: every pulse is recorded in the sticky register
  a_r9_pulse_logged: assert property (@(posedge clk) disable iff (rst)
    ((viol & err_sticky) == viol));

  // R10: the code names the lowest pulsing rule
  a_r10_code_lowest: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> (viol[viol_code] &&
      ((viol & ((NRULE'(1) << viol_code) - NRULE'(1))) == '0)));
endmodule

// File: rtl/sd_gap_monitor.sv
module sd_gap_monitor
  import sd_gap_pkg::*;
#(
  parameter int GAP_W      = 8,
  parameter int ACC_W      = 16,
  parameter int NSAC_SCALE = 100,
  parameter int NCR_MIN    = 2,
  parameter int NCR_MAX    = 64,
  parameter int NID_GAP    = 5,
  parameter int NRC_MIN    = 8,
  parameter int NCC_MIN    = 8,
  parameter int NWR_MIN    = 2,
  parameter int NST_GAP    = 2,
  parameter int NAC_MIN    = 2,
  parameter int TO_LIM     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_line,
  input  logic              cmd_start,
  input  logic              cmd_end,
  input  logic [2:0]        cmd_kind,
  input  logic              rsp_start,
  input  logic              rsp_end,
  input  logic              wdat_start,
  input  logic              rdat_start,
  input  logic              dat_stop,
  input  logic [7:0]        acc_taac,
  input  logic [7:0]        acc_nsac,
  input  logic [8:0]        err_clr,
  output logic [8:0]        viol,
  output logic              viol_valid,
  output logic [3:0]        viol_code,
  output logic [8:0]        err_sticky
);
  localparam int NTMR = 2;

  logic [GAP_W-1:0] gap_cnt [NTMR];
  logic [NTMR-1:0]  gap_rst;
  logic [ACC_W-1:0] acc_cnt;
  logic [ACC_W-1:0] acc_lim;
  logic [NRULE-1:0] viol_d;

  assign gap_rst[0] = cmd_end;
  assign gap_rst[1] = rsp_end;
  assign acc_lim    = ACC_W'(acc_taac) + ACC_W'(acc_nsac) * ACC_W'(NSAC_SCALE);

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    sd_gap_timer #(.W(GAP_W)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .restart (gap_rst[g]),
      .cnt     (gap_cnt[g])
    );
  end

  sd_gap_timer #(.W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (cmd_end && (cmd_kind == K_READ)),
    .cnt     (acc_cnt)
  );

  sd_gap_rules #(
    .GAP_W(GAP_W), .ACC_W(ACC_W), .NCR_MIN(NCR_MIN), .NCR_MAX(NCR_MAX),
    .NID_GAP(NID_GAP), .NRC_MIN(NRC_MIN), .NCC_MIN(NCC_MIN),
    .NWR_MIN(NWR_MIN), .NST_GAP(NST_GAP), .NAC_MIN(NAC_MIN), .TO_LIM(TO_LIM)
  ) u_rules (
    .clk        (clk),
    .rst        (rst),
    .cmd_line   (cmd_line),
    .cmd_start  (cmd_start),
    .cmd_end    (cmd_end),
    .cmd_kind   (cmd_kind),
    .rsp_start  (rsp_start),
    .rsp_end    (rsp_end),
    .wdat_start (wdat_start),
    .rdat_start (rdat_start),
    .dat_stop   (dat_stop),
    .acc_lim    (acc_lim),
    .t_cmd      (gap_cnt[0]),
    .t_rsp      (gap_cnt[1]),
    .t_acc      (acc_cnt),
    .viol_d     (viol_d)
  );

  sd_gap_log u_log (
    .clk        (clk),
    .rst        (rst),
    .viol_d     (viol_d),
    .err_clr    (err_clr),
    .viol       (viol),
    .viol_valid (viol_valid),
    .viol_code  (viol_code),
    .err_sticky (err_sticky)
  );

  // R2: an identification-gap pulse follows a response start
  a_r2_id_after_rsp: assert property (@(posedge clk) disable iff (rst)
    viol[V_ID_GAP] |-> $past(rsp_start));

  // R10: valid tracks the pulse vector
  a_r10_valid_any: assert property (@(posedge clk) disable iff (rst)
    viol_valid == (|viol));
endmodule

// File: tb/sim_sd_gap_monitor.sv
`timescale 1ns/1ps
module sim_sd_gap_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_line = 1'b1;
  logic       cmd_start = 1'b0, cmd_end = 1'b0, rsp_start = 1'b0, rsp_end = 1'b0;
  logic       wdat_start = 1'b0, rdat_start = 1'b0, dat_stop = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic [7:0] acc_taac = 8'd10, acc_nsac = 8'd0;
  logic [8:0] err_clr = '0;
  logic [8:0] viol, err_sticky;
  logic       viol_valid;
  logic [3:0] viol_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sd_gap_monitor u0 (
    .clk(clk), .rst(rst), .cmd_line(cmd_line), .cmd_start(cmd_start),
    .cmd_end(cmd_end), .cmd_kind(cmd_kind), .rsp_start(rsp_start),
    .rsp_end(rsp_end), .wdat_start(wdat_start), .rdat_start(rdat_start),
    .dat_stop(dat_stop), .acc_taac(acc_taac), .acc_nsac(acc_nsac),
    .err_clr(err_clr), .viol(viol), .viol_valid(viol_valid),
    .viol_code(viol_code), .err_sticky(err_sticky)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0 cmd_start 1 cmd_end 2 rsp_start 3 rsp_end 4 wdat 5 rdat 6 dat_stop
  task automatic send(int idx);
    case (idx)
      0: cmd_start = 1'b1;  1: cmd_end = 1'b1;   2: rsp_start = 1'b1;
      3: rsp_end = 1'b1;    4: wdat_start = 1'b1; 5: rdat_start = 1'b1;
      default: dat_stop = 1'b1;
    endcase
    @(negedge clk);
    {cmd_start, cmd_end, rsp_start, rsp_end, wdat_start, rdat_start, dat_stop} = '0;
  endtask

  task automatic gap(int a, int b, int g);
    send(a); idle(g - 1); send(b);
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 viol", viol, 0);
    chk("R11 valid", viol_valid, 0);
    chk("R11 code", viol_code, 0);
    chk("R11 sticky", err_sticky, 0);
  endtask

  task automatic t_ncr();
    do_reset(); cmd_kind = 3'd0;
    gap(1, 2, 2);  chk("R1 gap2", viol, 0);
    gap(1, 2, 1);  chk("R1 gap1", viol, 9'h001);
    gap(1, 2, 64); chk("R1 gap64", viol, 0);
    gap(1, 2, 65); chk("R1 gap65", viol, 9'h002);
  endtask

  task automatic t_nid();
    do_reset(); cmd_kind = 3'd1;
    gap(1, 2, 5); chk("R2 gap5", viol, 0);
    gap(1, 2, 4); chk("R2 gap4", viol, 9'h004);
    gap(1, 2, 6); chk("R2 gap6", viol, 9'h004);
    chk("R10 code id", viol_code, 2);
    cmd_kind = 3'd0;
  endtask

  task automatic t_nrc();
    do_reset();
    gap(3, 0, 7); chk("R3 gap7", viol, 9'h008);
    gap(3, 0, 8); chk("R3 gap8", viol, 0);
  endtask

  task automatic t_ncc();
    do_reset(); cmd_kind = 3'd0;
    gap(1, 0, 7); chk("R4 gap7", viol, 9'h010);
    gap(1, 0, 8); chk("R4 gap8", viol, 0);
  endtask

  task automatic t_nwr();
    do_reset(); cmd_kind = 3'd3;
    gap(1, 2, 3); idle(3); send(3);
    send(4);          chk("R5 gap1", viol[5], 1);
    send(3); idle(1); send(4); chk("R5 gap2", viol[5], 0);
    cmd_kind = 3'd0;
  endtask

  task automatic t_nst();
    do_reset(); cmd_kind = 3'd4;
    gap(1, 6, 2); chk("R6 gap2", viol[6], 0);
    gap(1, 6, 1); chk("R6 gap1", viol[6], 1);
    send(1); idle(2); chk("R6 miss2", viol[6], 0);
    idle(1);          chk("R6 miss3", viol[6], 1);
    cmd_kind = 3'd0;
  endtask

  task automatic t_nac();
    do_reset(); cmd_kind = 3'd2; acc_taac = 8'd10; acc_nsac = 8'd0;
    gap(1, 5, 10); chk("R7 gap10", viol[7], 0);
    gap(1, 5, 11); chk("R7 gap11", viol[7], 1);
    gap(1, 5, 1);  chk("R7 gap1", viol[7], 1);
    send(1); idle(10); chk("R7 miss10", viol[7], 0);
    idle(1);           chk("R7 miss11", viol[7], 1);
    acc_taac = 8'd0; acc_nsac = 8'd1;
    gap(1, 5, 100); chk("R7 scaled100", viol[7], 0);
    gap(1, 5, 101); chk("R7 scaled101", viol[7], 1);
    cmd_kind = 3'd0; acc_taac = 8'd10;
  endtask

  task automatic t_to();
    do_reset(); cmd_kind = 3'd0;
    send(1); idle(64); chk("R8 at64", viol[8], 0);
    idle(1);           chk("R8 at65", viol[8], 1);
    do_reset();
    send(1); cmd_line = 1'b0; @(negedge clk); cmd_line = 1'b1;
    idle(64);          chk("R8 startbit", err_sticky[8], 0);
  endtask

  task automatic t_sat();
    do_reset(); cmd_kind = 3'd0;
    gap(1, 2, 300); chk("R12 gap300", viol[1], 1);
  endtask

  task automatic t_sticky();
    do_reset(); cmd_kind = 3'd1;
    gap(1, 2, 4); chk("R9 set", err_sticky[2], 1);
    idle(5);      chk("R9 hold", err_sticky[2], 1);
    err_clr = 9'h004; @(negedge clk); err_clr = '0;
    chk("R9 clear", err_sticky[2], 0);
    send(1); idle(2);
    err_clr = 9'h004; send(2); err_clr = '0;
    chk("R9 set wins", err_sticky[2], 1);
    cmd_kind = 3'd0;
  endtask

  task automatic t_code();
    do_reset(); cmd_kind = 3'd0;
    send(3); send(1); send(0);
    chk("R10 both", viol, 9'h018);
    chk("R10 valid", viol_valid, 1);
    chk("R10 code", viol_code, 3);
    idle(1);
    chk("R10 valid low", viol_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all: watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset(); t_ncr(); t_nid(); t_nrc(); t_ncc(); t_nwr();
    t_nst(); t_nac(); t_to(); t_sat(); t_sticky(); t_code();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule